// File: doc/BRIEF.md
# PC-Card Bus Cycle Timing Sequencer

This block sets the strobe timing for one access to a PC-card style memory or I/O window. A request brings an address, a direction, write data, the target area (5 or 6) and the attributes of its page: a 3-bit space code and a single timing-select bit. The timing-select bit chooses one of two complete parameter sets. Each set holds a base wait, an extra low-speed wait, a setup count and a hold count. The idle gap after the access comes from a per-area field and does not depend on the timing-select bit.

The sequencer is a five-state machine: ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD and ST_GAP. A valid request in ST_IDLE with a usable space code moves it to ST_SETUP, or straight to ST_STROBE when the setup count is zero. ST_SETUP always goes to ST_STROBE. ST_STROBE goes to ST_HOLD, or to ST_GAP or ST_IDLE when the later phases have zero length. ST_HOLD goes to ST_GAP or ST_IDLE, and ST_GAP goes to ST_IDLE. Every phase counts down its latched length. A request with the reserved space code gives an error pulse and the machine stays in ST_IDLE.

Chip-select, both card enables and REG are active during ST_SETUP, ST_STROBE and ST_HOLD. RD or WE is active during ST_STROBE only. For a read, data is sampled on the last strobe cycle, and a one-clock done pulse follows the last active cycle.

Top module: `pccard_seq`

## Requirements
- R1: After reset, cs_n, ce1_n, ce2_n, reg_n, rd_n and we_n are high, and busy, done and err are low.
- R2: With req_tsel=0, parameter set A supplies the base wait, low-speed wait, setup and hold. With req_tsel=1, set B supplies all four.
- R3: RD or WE stays low for 1 + base + extra cycles. The base code gives 0..7 cycles. The 2-bit low-speed code maps 0,1,2,3 to 0, 15, 30 and 50 cycles.
- R4: The 3-bit setup code maps 0..7 to 0,1,2,3,6,9,12,15 cycles. For that many cycles, cs_n, ce1_n and REG are active before RD or WE falls.
- R5: The hold code uses the same mapping as setup. For that many cycles after RD or WE rises, the selects stay active and bus_addr and bus_wdata stay stable.
- R6: After the hold phase, busy stays high for an idle gap of 0..7 cycles. The gap comes from cfg_idle5 for area 5 (req_area6=0) and from cfg_idle6 for area 6, whatever req_tsel is.
- R7: reg_n goes low during the access for space codes 001, 010, 011, 110 and 111. It stays high for 100 and 101.
- R8: ce1_n goes low for every valid space code. ce2_n goes low only when space code bit 0 is 1 (codes 001, 011, 101 and 111).
- R9: A request with space code 000 gives err high for exactly the cycle after the request edge. No strobe moves and busy stays low.
- R10: done is high for one cycle, right after the last cycle with cs_n low. For a read, rdata then holds the card data sampled on the last strobe cycle. A read drives only rd_n and a write only we_n.
- R11: A request presented while busy is high is ignored and starts no second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, sampled in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area6 | input | 1 | 0 = area 5, 1 = area 6 |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_space | input | 3 | Page space code |
| req_tsel | input | 1 | Page timing-set select |
| cfg_wait_a | input | 3 | Set A base wait |
| cfg_slow_a | input | 2 | Set A low-speed wait code |
| cfg_setup_a | input | 3 | Set A setup code |
| cfg_hold_a | input | 3 | Set A hold code |
| cfg_wait_b | input | 3 | Set B base wait |
| cfg_slow_b | input | 2 | Set B low-speed wait code |
| cfg_setup_b | input | 3 | Set B setup code |
| cfg_hold_b | input | 3 | Set B hold code |
| cfg_idle5 | input | 3 | Area 5 idle gap |
| cfg_idle6 | input | 3 | Area 6 idle gap |
| card_rdata | input | DW | Data from the card |
| bus_addr | output | AW | Latched address |
| bus_wdata | output | DW | Latched write data |
| cs_n | output | 1 | Chip select, active low |
| ce1_n | output | 1 | Low-byte card enable, active low |
| ce2_n | output | 1 | High-byte card enable, active low |
| reg_n | output | 1 | Attribute/I-O select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| rdata | output | DW | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved-code rejection pulse |
| busy | output | 1 | Access or idle gap in progress |

## Verification
The assertions check on every cycle that RD and WE are never low together, and that a strobe is low only while chip-select is low. They also check that select and address lines do not move while chip-select stays low, that an error pulse comes with no strobe activity, that done never lasts two cycles, and that chip-select is released whenever busy is low. The setup, strobe, hold and gap lengths depend on which parameter set and which area field were chosen. The REG and high-byte-enable decode per space code, the captured read data and the dropping of requests during a busy access are shown only by the bench's directed scenarios, which count cycles against values computed from the requirements.

// File: rtl/pccard_pkg.sv
package pccard_pkg;
    localparam int CODE_W = 3;
    localparam int SLOW_W = 2;
    localparam int SH_W   = 4;
    localparam int CNT_W  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic [SH_W-1:0]   setup;
        logic [CNT_W-1:0]  strobe;
        logic [SH_W-1:0]   hold;
        logic [CODE_W-1:0] gap;
    } timing_t;
endpackage

// File: rtl/pccard_timing_sel.sv
module pccard_timing_sel
    import pccard_pkg::*;
(
    input  logic              tsel,
    input  logic              area6,
    input  logic [CODE_W-1:0] wait_a,
    input  logic [SLOW_W-1:0] slow_a,
    input  logic [CODE_W-1:0] setup_a,
    input  logic [CODE_W-1:0] hold_a,
    input  logic [CODE_W-1:0] wait_b,
    input  logic [SLOW_W-1:0] slow_b,
    input  logic [CODE_W-1:0] setup_b,
    input  logic [CODE_W-1:0] hold_b,
    input  logic [CODE_W-1:0] idle5,
    input  logic [CODE_W-1:0] idle6,
    output timing_t           tm
);
    function automatic logic [SH_W-1:0] sh_len(input logic [CODE_W-1:0] c);
        logic [SH_W-1:0] w;
        w = SH_W'(c);
        if (!c[2]) return w;
        return SH_W'(3 * (w - SH_W'(2)));
    endfunction

    function automatic logic [CNT_W-1:0] slow_len(input logic [SLOW_W-1:0] c);
        unique case (c)
            2'd0:    return CNT_W'(0);
            2'd1:    return CNT_W'(15);
            2'd2:    return CNT_W'(30);
            default: return CNT_W'(50);
        endcase
    endfunction

    logic [CODE_W-1:0] wait_s, setup_s, hold_s;
    logic [SLOW_W-1:0] slow_s;

    always_comb begin
        wait_s  = tsel ? wait_b  : wait_a;
        slow_s  = tsel ? slow_b  : slow_a;
        setup_s = tsel ? setup_b : setup_a;
        hold_s  = tsel ? hold_b  : hold_a;
        tm.setup  = sh_len(setup_s);
        tm.hold   = sh_len(hold_s);
        tm.strobe = CNT_W'(1) + CNT_W'(wait_s) + slow_len(slow_s);
        tm.gap    = area6 ? idle6 : idle5;
    end
endmodule

// File: rtl/pccard_space_dec.sv
module pccard_space_dec
    import pccard_pkg::*;
(
    input  logic [CODE_W-1:0] space,
    output logic              rsv,
    output logic              wide,
    output logic              reg_act
);
    always_comb begin
        rsv     = (space == '0);
        wide    = space[0];
        reg_act = !(space[2] && !space[1]);
    end
endmodule

// File: rtl/pccard_seq.sv
module pccard_seq
    import pccard_pkg::*;
#(
    parameter int AW = 26,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_area6,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [2:0]        req_space,
    input  logic              req_tsel,
    input  logic [2:0]        cfg_wait_a,
    input  logic [1:0]        cfg_slow_a,
    input  logic [2:0]        cfg_setup_a,
    input  logic [2:0]        cfg_hold_a,
    input  logic [2:0]        cfg_wait_b,
    input  logic [1:0]        cfg_slow_b,
    input  logic [2:0]        cfg_setup_b,
    input  logic [2:0]        cfg_hold_b,
    input  logic [2:0]        cfg_idle5,
    input  logic [2:0]        cfg_idle6,
    input  logic [DW-1:0]     card_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              cs_n,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              reg_n,
    output logic              rd_n,
    output logic              we_n,
    output logic [DW-1:0]     rdata,
    output logic              done,
    output logic              err,
    output logic              busy
);
    seq_state_t       st, nxt;
    timing_t          tm_new, tm_q;
    logic [CNT_W-1:0] cnt, load_len;
    logic             sp_rsv, sp_wide, sp_reg;
    logic             wide_q, reg_q, wr_q;
    logic             accept, active;

    pccard_timing_sel u_tsel (
        .tsel(req_tsel), .area6(req_area6),
        .wait_a(cfg_wait_a), .slow_a(cfg_slow_a), .setup_a(cfg_setup_a), .hold_a(cfg_hold_a),
        .wait_b(cfg_wait_b), .slow_b(cfg_slow_b), .setup_b(cfg_setup_b), .hold_b(cfg_hold_b),
        .idle5(cfg_idle5), .idle6(cfg_idle6), .tm(tm_new)
    );

    pccard_space_dec u_sdec (
        .space(req_space), .rsv(sp_rsv), .wide(sp_wide), .reg_act(sp_reg)
    );

    assign accept = (st == ST_IDLE) && req_valid && !sp_rsv;

    // next-state selection: zero-length phases are skipped
    always_comb begin
        nxt      = st;
        load_len = '0;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (tm_new.setup != '0) begin
                        nxt = ST_SETUP;  load_len = CNT_W'(tm_new.setup);
                    end else begin
                        nxt = ST_STROBE; load_len = tm_new.strobe;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    nxt = ST_STROBE; load_len = tm_q.strobe;
                end
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    if (tm_q.hold != '0) begin
                        nxt = ST_HOLD; load_len = CNT_W'(tm_q.hold);
                    end else if (tm_q.gap != '0) begin
                        nxt = ST_GAP;  load_len = CNT_W'(tm_q.gap);
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    if (tm_q.gap != '0) begin
                        nxt = ST_GAP; load_len = CNT_W'(tm_q.gap);
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (cnt == '0) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register, counter and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            tm_q      <= '0;
            wide_q    <= 1'b0;
            reg_q     <= 1'b0;
            wr_q      <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rdata     <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt != st)        cnt <= load_len - CNT_W'(1);
            else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
            if (accept) begin
                tm_q      <= tm_new;
                wide_q    <= sp_wide;
                reg_q     <= sp_reg;
                wr_q      <= req_write;
                bus_addr  <= req_addr;
                bus_wdata <= req_wdata;
            end
            if (st == ST_STROBE && cnt == '0 && !wr_q) rdata <= card_rdata;
            done <= (cnt == '0) && ((st == ST_HOLD) ||
                                    (st == ST_STROBE && tm_q.hold == '0));
            err  <= (st == ST_IDLE) && req_valid && sp_rsv;
        end
    end

    // strobe outputs decoded from state
    always_comb begin
        active = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
        cs_n   = !active;
        ce1_n  = !active;
        ce2_n  = !(active && wide_q);
        reg_n  = !(active && reg_q);
        rd_n   = !(st == ST_STROBE && !wr_q);
        we_n   = !(st == ST_STROBE && wr_q);
        busy   = (st != ST_IDLE);
    end
endmodule

// File: rtl/pccard_seq_chk.sv
module pccard_seq_chk #(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          cs_n,
    input logic          ce1_n,
    input logic          ce2_n,
    input logic          reg_n,
    input logic          rd_n,
    input logic          we_n,
    input logic          done,
    input logic          err,
    input logic          busy
);
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !we_n)); // R10
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !we_n) |-> (!cs_n && !ce1_n)); // R4
    AST_SELECTS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(reg_n) && $stable(ce2_n) && $stable(bus_addr))); // R5
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && rd_n && we_n && !busy)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && ce1_n && ce2_n && reg_n)); // R6
endmodule

bind pccard_seq pccard_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .cs_n(cs_n), .ce1_n(ce1_n),
    .ce2_n(ce2_n), .reg_n(reg_n), .rd_n(rd_n), .we_n(we_n), .done(done),
    .err(err), .busy(busy)
);

// File: tb/sim_pccard_seq.sv
module sim_pccard_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 26;
    localparam int DW = 16;
    localparam int WIN = 120;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_area6 = 0, req_tsel = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, card_rdata = '0;
    logic [2:0] req_space = 3'd4;
    logic [2:0] cfg_wait_a = 0, cfg_setup_a = 0, cfg_hold_a = 0;
    logic [2:0] cfg_wait_b = 0, cfg_setup_b = 0, cfg_hold_b = 0;
    logic [1:0] cfg_slow_a = 0, cfg_slow_b = 0;
    logic [2:0] cfg_idle5 = 0, cfg_idle6 = 0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, rdata;
    logic cs_n, ce1_n, ce2_n, reg_n, rd_n, we_n, done, err, busy;

    int checks = 0, errors = 0;
    // measurement results
    int m_cs, m_stb, m_first_stb, m_done_idx, m_done_cnt, m_busy, m_runs, m_bad_hold;
    logic m_reg, m_ce1, m_ce2;
    logic [DW-1:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    pccard_seq #(.AW(AW), .DW(DW)) u0 (.*);

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sh_map(input int c);
        case (c)
            0: return 0;  1: return 1;  2: return 2;  3: return 3;
            4: return 6;  5: return 9;  6: return 12; default: return 15;
        endcase
    endfunction

    function automatic int slow_map(input int c);
        case (c)
            0: return 0; 1: return 15; 2: return 30; default: return 50;
        endcase
    endfunction

    // issue one request and observe WIN cycles; inj>=0 re-raises req_valid while busy
    task automatic run_access(input int inj);
        bit prev_cs;
        m_cs = 0; m_stb = 0; m_first_stb = -1; m_done_idx = -1; m_done_cnt = 0;
        m_busy = 0; m_runs = 0; m_bad_hold = 0; prev_cs = 1;
        m_reg = 1; m_ce1 = 1; m_ce2 = 1; m_rdata = '0;
        @(negedge clk);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < WIN; i++) begin
            if (i == inj) req_valid = 1;
            if (i == inj + 2) req_valid = 0;
            if (!cs_n) begin
                if (prev_cs) begin
                    m_runs++;
                    m_reg = reg_n; m_ce1 = ce1_n; m_ce2 = ce2_n;
                end
                m_cs++;
                if (bus_addr != req_addr || bus_wdata != req_wdata) m_bad_hold++;
            end
            prev_cs = cs_n;
            if (!rd_n || !we_n) begin
                m_stb++;
                if (m_first_stb < 0) m_first_stb = i;
            end
            if (done) begin
                m_done_cnt++;
                if (m_done_idx < 0) begin m_done_idx = i; m_rdata = rdata; end
            end
            if (busy) m_busy++;
            @(negedge clk);
        end
    endtask

    task automatic expect_timing(input string tag, input int s, input int w,
                                 input int h, input int g);
        chk(m_first_stb == s, {tag, " setup"}, m_first_stb, s);
        chk(m_stb == w, {tag, " strobe"}, m_stb, w);
        chk(m_cs == s + w + h, {tag, " cs span"}, m_cs, s + w + h);
        chk(m_done_idx == s + w + h, {tag, " done index"}, m_done_idx, s + w + h);
        chk(m_done_cnt == 1, {tag, " done count"}, m_done_cnt, 1);
        chk(m_busy == s + w + h + g, {tag, " busy span"}, m_busy, s + w + h + g);
    endtask

    task automatic t_reset;
        chk(cs_n && ce1_n && ce2_n && reg_n, "R1 selects high", 0, 1);
        chk(rd_n && we_n, "R1 strobes high", 0, 1);
        chk(!busy && !done && !err, "R1 flags low", 0, 1);
    endtask

    task automatic t_set_a_read;
        cfg_wait_a = 2; cfg_slow_a = 1; cfg_setup_a = 4; cfg_hold_a = 2;
        cfg_wait_b = 6; cfg_slow_b = 0; cfg_setup_b = 1; cfg_hold_b = 7;
        cfg_idle5 = 3; cfg_idle6 = 5;
        req_tsel = 0; req_area6 = 0; req_write = 0; req_space = 3'b101;
        req_addr = 26'h12345; req_wdata = 16'h0; card_rdata = 16'hBEEF;
        run_access(-1);
        expect_timing("R2 R3 R4 R5 R6 set A read", 6, 18, 2, 3);
        chk(m_rdata == 16'hBEEF, "R10 read data", int'(m_rdata), 16'hBEEF);
        chk(m_reg == 1 && m_ce2 == 0, "R7 R8 common 16-bit", {m_reg, m_ce2}, 2'b10);
        chk(m_bad_hold == 0, "R5 addr stable", m_bad_hold, 0);
    endtask

    task automatic t_set_b_write;
        req_tsel = 1; req_area6 = 1; req_write = 1; req_space = 3'b110;
        req_addr = 26'h2A5A5; req_wdata = 16'hC3A5;
        run_access(-1);
        expect_timing("R2 R5 R6 set B write", 1, 7, 15, 5);
        chk(m_reg == 0 && m_ce2 == 1, "R7 R8 attr 8-bit", {m_reg, m_ce2}, 2'b01);
        chk(m_bad_hold == 0, "R5 wdata stable", m_bad_hold, 0);
    endtask

    task automatic t_area_vs_tsel;
        req_tsel = 1; req_area6 = 0; req_write = 0; req_space = 3'b100;
        run_access(-1);
        expect_timing("R6 area5 gap with set B", 1, 7, 15, 3);
        req_tsel = 0; req_area6 = 1;
        run_access(-1);
        expect_timing("R6 area6 gap with set A", 6, 18, 2, 5);
    endtask

    task automatic t_slow_max;
        cfg_wait_a = 7; cfg_slow_a = 3; cfg_setup_a = 0; cfg_hold_a = 0;
        cfg_idle5 = 0; req_tsel = 0; req_area6 = 0; req_write = 0;
        card_rdata = 16'h5A0F;
        run_access(-1);
        expect_timing("R3 slow 50 zero phases", 0, 58, 0, 0);
        chk(m_rdata == 16'h5A0F, "R10 read data no hold", int'(m_rdata), 16'h5A0F);
        for (int c = 0; c < 3; c++) begin
            cfg_wait_a = 3'(c * 3); cfg_slow_a = 2'(c);
            run_access(-1);
            chk(m_stb == 1 + c * 3 + slow_map(c), "R3 strobe length", m_stb, 1 + c * 3 + slow_map(c));
        end
    endtask

    task automatic t_setup_hold_map;
        cfg_wait_a = 0; cfg_slow_a = 0; cfg_idle5 = 1; req_tsel = 0; req_area6 = 0;
        for (int c = 0; c < 8; c++) begin
            cfg_setup_a = 3'(c); cfg_hold_a = 3'(7 - c);
            run_access(-1);
            chk(m_first_stb == sh_map(c), "R4 setup map", m_first_stb, sh_map(c));
            chk(m_cs == sh_map(c) + 1 + sh_map(7 - c), "R5 hold map", m_cs, sh_map(c) + 1 + sh_map(7 - c));
        end
    endtask

    task automatic t_space_decode;
        cfg_setup_a = 1; cfg_hold_a = 1; cfg_wait_a = 1; req_tsel = 0;
        for (int c = 1; c < 8; c++) begin
            req_space = 3'(c);
            run_access(-1);
            chk(m_reg == ((c == 4 || c == 5) ? 1'b1 : 1'b0), "R7 reg decode", m_reg, (c == 4 || c == 5) ? 1 : 0);
            chk(m_ce1 == 0, "R8 ce1 decode", m_ce1, 0);
            chk(m_ce2 == ((c % 2 == 1) ? 1'b0 : 1'b1), "R8 ce2 decode", m_ce2, (c % 2 == 1) ? 0 : 1);
        end
    endtask

    task automatic t_reserved;
        req_space = 3'b000;
        @(negedge clk);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(err == 1, "R9 err pulse", err, 1);
        chk(!busy && cs_n, "R9 no start", busy, 0);
        @(negedge clk);
        chk(err == 0, "R9 err single", err, 0);
        begin
            int act = 0;
            for (int i = 0; i < 10; i++) begin
                if (!cs_n || !rd_n || !we_n || busy) act++;
                @(negedge clk);
            end
            chk(act == 0, "R9 strobes quiet", act, 0);
        end
    endtask

    task automatic t_busy_ignore;
        req_space = 3'b011; cfg_setup_a = 2; cfg_hold_a = 2; cfg_wait_a = 5; cfg_idle5 = 2;
        req_tsel = 0; req_area6 = 0;
        run_access(4);
        chk(m_runs == 1, "R11 request while busy ignored", m_runs, 1);
        chk(m_done_cnt == 1, "R11 single done", m_done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_set_a_read();
        t_set_b_write();
        t_area_vs_tsel();
        t_slow_max();
        t_setup_hold_map();
        t_space_decode();
        t_reserved();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule